// File: doc/BRIEF.md
# I2C Target with Pin-Strapped Address

This block is the target (slave) side of a two-wire serial bus, clocked entirely by the local system clock. SCL and SDA are brought in through a synchroniser and watched for edges and for START and STOP conditions. After each START, the first byte is compared with the block's own 7-bit address. The upper bits of that address are a build-time constant and the low bits come from strap pins. When general-call acceptance is enabled, the all-zero address is accepted as well. A matching address produces a one-cycle event together with the transfer direction.

When the master writes, each received byte is offered to the local side on a valid/ready handshake. The block acknowledges the byte only after the local side has taken it. When the master reads, the block asks the local side for a byte on a second valid/ready handshake and shifts that byte out. In both directions the block holds SCL low while the local side is not ready.

The pad drivers are not part of the block. The two enable outputs mean "pull this line low". The reserved START-byte pattern is never acknowledged.

Top module: `i2c_target`

## Requirements
- R1: The address byte {own address, direction} is acknowledged: sdaOe is 1 during the 9th SCL pulse, so the line reads 0. The own address is FIXED_ADDR[6:PIN_BITS] followed by addrPins. Direction bit 0 means write and 1 means read.
- R2: An address byte that matches neither the own address nor an accepted general call is not acknowledged. No later byte is acknowledged or delivered until the next START.
- R3: In a write, each data byte is assembled MSB first and presented on rxData with rxValid = 1. While rxValid is 1 and rxReady is 0, rxData holds steady. The byte is acknowledged after the handshake.
- R4: While a received byte waits for rxReady, sclOe is held at 1, so the SCL line stays low even when the master releases it.
- R5: In a read, txReady is 1 and SCL is held low until txValid is 1. The accepted txData is then driven MSB first, one bit per SCL pulse. sdaOe never changes while SCL is seen high outside START and STOP.
- R6: When the master answers a sent byte with no acknowledge (SDA high on the 9th pulse), the block releases SDA. It requests no further byte until the next START.
- R7: When the master acknowledges a sent byte (SDA low on the 9th pulse), the block requests and sends the next byte.
- R8: With gcEnable = 1, the address byte 0x00 is acknowledged, matchGc reads 1, and the data bytes that follow are delivered. With gcEnable = 0, the byte 0x00 is not acknowledged.
- R9: The address byte 0x01 is never acknowledged, whatever gcEnable is.
- R10: Every accepted address gives addrMatch = 1 for exactly one clock cycle. At that moment matchRead carries the direction bit.
- R11: A repeated START, with no STOP in between, restarts address decoding. A write followed by a repeated START with a read address continues as a read.
- R12: After a STOP, both sclOe and sdaOe are 0.
- R13: After reset, sdaOe, sclOe, rxValid, txReady and addrMatch are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sensed level of the SCL line |
| sdaIn | input | 1 | Sensed level of the SDA line |
| sclOe | output | 1 | 1 pulls SCL low (clock stretch) |
| sdaOe | output | 1 | 1 pulls SDA low |
| addrPins | input | PIN_BITS | Strap pins forming the low address bits |
| gcEnable | input | 1 | Accept the general-call address |
| rxData | output | 8 | Received data byte |
| rxValid | output | 1 | Received byte is waiting |
| rxReady | input | 1 | Local side takes the received byte |
| txData | input | 8 | Byte to send to the master |
| txValid | input | 1 | txData is available |
| txReady | output | 1 | Block requests a byte to send |
| addrMatch | output | 1 | One-cycle pulse on an accepted address |
| matchRead | output | 1 | Direction of the last accepted address (1 = read) |
| matchGc | output | 1 | Last accepted address was the general call |

## Verification
The assertions rely on three assumptions about the master. It moves SDA only while SCL is low, except when it makes a START or a STOP. It never makes a START or a STOP while the target is driving SDA or holding SCL. Each SCL phase lasts well beyond the three-cycle delay of the synchroniser and edge detector. The bench master keeps every SCL-low phase at ten clocks, with SDA set in the middle of it, and every SCL-high phase at ten clocks. It waits on the wired-AND SCL line before timing a high phase. It also changes rxReady and txValid only just after a rising clock edge.

// File: rtl/i2c_target_pkg.sv
`timescale 1ns/1ps
package i2c_target_pkg;
  localparam int BYTE_BITS = 8;
  localparam int ADDR_BITS = 7;
  localparam int CNT_W     = $clog2(BYTE_BITS + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ACK, ST_RX, ST_RXHOLD,
    ST_TXLOAD, ST_TX, ST_TXMACK, ST_WAIT
  } busState_t;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic shiftIn;
    logic loadTx;
    logic shiftTx;
  } dpCtl_t;
endpackage

// File: rtl/i2c_target_dp.sv
`timescale 1ns/1ps
module i2c_target_dp
  import i2c_target_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  logic [ADDR_BITS-1:0] ownAddr,
  input  logic                 gcEnable,
  input  logic [BYTE_BITS-1:0] txByte,
  input  dpCtl_t               ctl,
  output logic                 sclS,
  output logic                 sdaS,
  output logic                 sclRise,
  output logic                 sclFall,
  output logic                 startDet,
  output logic                 stopDet,
  output logic [CNT_W-1:0]     bitCnt,
  output logic [BYTE_BITS-1:0] shiftReg,
  output logic                 addrHit,
  output logic                 gcHit
);
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;

  // Synchronisers reset to the idle (released) bus level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS     = sclPipe[SYNC_STAGES-1];
  assign sdaS     = sdaPipe[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (ctl.cntClr) begin
      bitCnt <= '0;
    end else if (ctl.cntInc) begin
      bitCnt <= bitCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (ctl.loadTx) begin
      shiftReg <= txByte;
    end else if (ctl.shiftIn) begin
      shiftReg <= {shiftReg[BYTE_BITS-2:0], sdaS};
    end else if (ctl.shiftTx) begin
      shiftReg <= {shiftReg[BYTE_BITS-2:0], 1'b1};
    end
  end

  // Address decode: own address (never zero) or a general-call write when enabled.
  // The byte 0x01 is rejected since neither term can match it.
  logic ownHit;
  assign ownHit  = (ownAddr != '0) && (shiftReg[BYTE_BITS-1:1] == ownAddr);
  assign gcHit   = (shiftReg == '0);
  assign addrHit = ownHit | (gcEnable & gcHit);

  a_r11_start_clears_count: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (bitCnt == '0));
endmodule

// File: rtl/i2c_target_ctl.sv
`timescale 1ns/1ps
module i2c_target_ctl
  import i2c_target_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclS,
  input  logic                 sdaS,
  input  logic                 sclRise,
  input  logic                 sclFall,
  input  logic                 startDet,
  input  logic                 stopDet,
  input  logic [CNT_W-1:0]     bitCnt,
  input  logic [BYTE_BITS-1:0] shiftReg,
  input  logic                 addrHit,
  input  logic                 gcHit,
  input  logic                 rxReady,
  input  logic                 txValid,
  output dpCtl_t               ctl,
  output logic                 sdaOe,
  output logic                 sclOe,
  output logic                 rxValid,
  output logic                 txReady,
  output logic                 addrMatch,
  output logic                 matchRead,
  output logic                 matchGc
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_BITS);

  busState_t state, nxt;
  logic dirRead, mNack, matchNow;

  always_comb begin
    nxt      = state;
    ctl      = '0;
    matchNow = 1'b0;
    if (startDet) begin
      nxt        = ST_ADDR;
      ctl.cntClr = 1'b1;
    end else if (stopDet) begin
      nxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (sclRise) begin
            ctl.shiftIn = 1'b1;
            ctl.cntInc  = 1'b1;
          end else if (sclFall && bitCnt == FULL_CNT) begin
            ctl.cntClr = 1'b1;
            if (addrHit) begin
              nxt      = ST_ACK;
              matchNow = 1'b1;
            end else begin
              nxt = ST_WAIT;
            end
          end
        end
        ST_ACK: begin
          if (sclRise) begin
            ctl.cntInc = 1'b1;
          end else if (sclFall && bitCnt != '0) begin
            ctl.cntClr = 1'b1;
            nxt        = dirRead ? ST_TXLOAD : ST_RX;
          end
        end
        ST_RX: begin
          if (sclRise) begin
            ctl.shiftIn = 1'b1;
            ctl.cntInc  = 1'b1;
          end else if (sclFall && bitCnt == FULL_CNT) begin
            nxt = ST_RXHOLD;
          end
        end
        ST_RXHOLD: begin
          if (rxReady) begin
            ctl.cntClr = 1'b1;
            nxt        = ST_ACK;
          end
        end
        ST_TXLOAD: begin
          if (txValid) begin
            ctl.loadTx = 1'b1;
            ctl.cntClr = 1'b1;
            nxt        = ST_TX;
          end
        end
        ST_TX: begin
          if (sclRise) begin
            ctl.cntInc = 1'b1;
          end else if (sclFall) begin
            if (bitCnt == FULL_CNT) begin
              ctl.cntClr = 1'b1;
              nxt        = ST_TXMACK;
            end else begin
              ctl.shiftTx = 1'b1;
            end
          end
        end
        ST_TXMACK: begin
          if (sclRise) begin
            ctl.cntInc = 1'b1;
          end else if (sclFall && bitCnt != '0) begin
            ctl.cntClr = 1'b1;
            nxt        = mNack ? ST_WAIT : ST_TXLOAD;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      dirRead   <= 1'b0;
      mNack     <= 1'b0;
      addrMatch <= 1'b0;
      matchRead <= 1'b0;
      matchGc   <= 1'b0;
    end else begin
      state     <= nxt;
      addrMatch <= matchNow;
      if (matchNow) begin
        dirRead   <= shiftReg[0];
        matchRead <= shiftReg[0];
        matchGc   <= gcHit;
      end
      if (state == ST_TXMACK && sclRise && !startDet && !stopDet) begin
        mNack <= sdaS;
      end
    end
  end

  always_comb begin
    unique case (state)
      ST_ACK:  sdaOe = 1'b1;
      ST_TX:   sdaOe = ~shiftReg[BYTE_BITS-1];
      default: sdaOe = 1'b0;
    endcase
  end

  assign sclOe   = (state == ST_RXHOLD) || (state == ST_TXLOAD);
  assign rxValid = (state == ST_RXHOLD);
  assign txReady = (state == ST_TXLOAD);

  a_r5_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && $past(sclS)) |-> $stable(sdaOe));
  a_r9_start_byte_no_ack: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && sclFall && !startDet && !stopDet &&
     bitCnt == FULL_CNT && shiftReg == 8'h01) |=> !sdaOe);
  a_r10_match_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    addrMatch |=> !addrMatch);
  a_r12_release_after_stop: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (!sclOe && !sdaOe));
endmodule

// File: rtl/i2c_target.sv
`timescale 1ns/1ps
module i2c_target
  import i2c_target_pkg::*;
#(
  parameter logic [6:0] FIXED_ADDR  = 7'h48,
  parameter int         PIN_BITS    = 2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  output logic                sclOe,
  output logic                sdaOe,
  input  logic [PIN_BITS-1:0] addrPins,
  input  logic                gcEnable,
  output logic [7:0]          rxData,
  output logic                rxValid,
  input  logic                rxReady,
  input  logic [7:0]          txData,
  input  logic                txValid,
  output logic                txReady,
  output logic                addrMatch,
  output logic                matchRead,
  output logic                matchGc
);
  logic [ADDR_BITS-1:0] ownAddr;

  generate
    if (PIN_BITS >= ADDR_BITS) begin : g_allPins
      assign ownAddr = addrPins[ADDR_BITS-1:0];
    end else begin : g_mixed
      assign ownAddr = {FIXED_ADDR[ADDR_BITS-1:PIN_BITS], addrPins};
    end
  endgenerate

  dpCtl_t               ctl;
  logic                 sclS, sdaS, sclRise, sclFall, startDet, stopDet;
  logic [CNT_W-1:0]     bitCnt;
  logic [BYTE_BITS-1:0] shiftReg;
  logic                 addrHit, gcHit;

  i2c_target_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ownAddr(ownAddr), .gcEnable(gcEnable), .txByte(txData), .ctl(ctl),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .bitCnt(bitCnt),
    .shiftReg(shiftReg), .addrHit(addrHit), .gcHit(gcHit)
  );

  i2c_target_ctl u_ctl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet),
    .stopDet(stopDet), .bitCnt(bitCnt), .shiftReg(shiftReg),
    .addrHit(addrHit), .gcHit(gcHit), .rxReady(rxReady), .txValid(txValid),
    .ctl(ctl), .sdaOe(sdaOe), .sclOe(sclOe), .rxValid(rxValid),
    .txReady(txReady), .addrMatch(addrMatch), .matchRead(matchRead),
    .matchGc(matchGc)
  );

  assign rxData = shiftReg;

  a_r3_rx_byte_held: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> (rxValid && $stable(rxData)));
endmodule

// File: tb/i2c_target_test.sv
`timescale 1ns/1ps
module i2c_target_test;
  localparam int Q = 5;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic sclOe, sdaOe;
  logic [1:0] addrPins = 2'b01;
  logic gcEnable = 1'b0;
  logic [7:0] rxData;
  logic rxValid;
  logic rxReady = 1'b1;
  logic [7:0] txData = 8'h00;
  logic txValid = 1'b0;
  logic txReady;
  logic addrMatch, matchRead, matchGc;
  wire sclLine = sclDrv & ~sclOe;
  wire sdaLine = sdaDrv & ~sdaOe;

  i2c_target uut (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclOe(sclOe), .sdaOe(sdaOe), .addrPins(addrPins), .gcEnable(gcEnable),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .addrMatch(addrMatch), .matchRead(matchRead), .matchGc(matchGc)
  );

  int nCompared = 0, nMismatched = 0;
  int stretchCyc = 0;
  logic [7:0] rxCap [0:15];
  int rxCnt = 0;
  int matchCnt = 0;
  logic lastRead = 1'b0, lastGc = 1'b0;
  logic [7:0] txMem [0:3];
  int txIdx = 0, txLimit = 0;
  logic txEnable = 1'b0;
  bit finished = 0;

  // own address with pins 01: {10010, 01} = 0x49 -> write 0x92, read 0x93
  localparam logic [7:0] OWN_W = 8'h92;
  localparam logic [7:0] OWN_R = 8'h93;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCompared++;
    if (act !== exp) begin
      nMismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitors
  initial forever begin
    @(negedge clk);
    if (rxValid && rxReady) begin
      rxCap[rxCnt[3:0]] = rxData;
      rxCnt++;
    end
    if (addrMatch) begin
      matchCnt++;
      lastRead = matchRead;
      lastGc = matchGc;
    end
  end

  initial forever begin
    @(negedge clk);
    txValid = txEnable && (txIdx < txLimit);
    txData  = txMem[txIdx[1:0]];
    if (txReady && txValid) begin
      @(posedge clk);
      #1;
      txIdx++;
    end
  end

  // bus master primitives
  task automatic sclHigh();
    sclDrv = 1'b1;
    @(negedge clk);
    while (sclLine !== 1'b1) begin
      stretchCyc++;
      @(negedge clk);
    end
  endtask

  task automatic busStart();
    if (sclDrv == 1'b0) begin
      waitClk(Q); sdaDrv = 1'b1; waitClk(Q);
      sclHigh(); waitClk(H);
    end
    sdaDrv = 1'b0; waitClk(H);
    sclDrv = 1'b0;
  endtask

  task automatic busStop();
    waitClk(Q); sdaDrv = 1'b0; waitClk(Q);
    sclHigh(); waitClk(H);
    sdaDrv = 1'b1; waitClk(H);
  endtask

  task automatic writeBit(input logic b);
    waitClk(Q); sdaDrv = b; waitClk(Q);
    sclHigh(); waitClk(H);
    sclDrv = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) writeBit(b[i]);
    waitClk(Q); sdaDrv = 1'b1; waitClk(Q);
    sclHigh(); waitClk(H/2);
    ack = sdaLine;
    waitClk(H/2);
    sclDrv = 1'b0;
  endtask

  task automatic readByte(output logic [7:0] d, input logic mAck);
    for (int i = 7; i >= 0; i--) begin
      waitClk(Q); sdaDrv = 1'b1; waitClk(Q);
      sclHigh(); waitClk(H/2);
      d[i] = sdaLine;
      waitClk(H/2);
      sclDrv = 1'b0;
    end
    writeBit(mAck);
  endtask

  task automatic setRxReady(input logic v);
    @(posedge clk); #1; rxReady = v;
  endtask

  task automatic setTxEnable(input logic v);
    @(posedge clk); #1; txEnable = v;
  endtask

  // scenarios
  task automatic t_reset();
    check("R13 sdaOe", sdaOe, 0);
    check("R13 sclOe", sclOe, 0);
    check("R13 rxValid", rxValid, 0);
    check("R13 txReady", txReady, 0);
    check("R13 addrMatch", addrMatch, 0);
  endtask

  task automatic t_write();
    logic ack;
    int m0 = matchCnt, r0 = rxCnt;
    busStart();
    writeByte(OWN_W, ack);
    check("R1 address ack", ack, 0);
    check("R10 one match pulse", matchCnt - m0, 1);
    check("R10 matchRead write", lastRead, 0);
    writeByte(8'hA5, ack);
    check("R3 byte1 ack", ack, 0);
    writeByte(8'h3C, ack);
    check("R3 byte2 ack", ack, 0);
    check("R3 byte count", rxCnt - r0, 2);
    check("R3 byte1 data", rxCap[r0[3:0]], 8'hA5);
    check("R3 byte2 data", rxCap[r0[3:0]+4'd1], 8'h3C);
    busStop();
    waitClk(4);
    check("R12 sclOe after stop", sclOe, 0);
    check("R12 sdaOe after stop", sdaOe, 0);
  endtask

  task automatic t_wrongAddr();
    logic ack;
    int m0 = matchCnt, r0 = rxCnt;
    busStart();
    writeByte(8'h90, ack);
    check("R2 no address ack", ack, 1);
    writeByte(8'h55, ack);
    check("R2 no data ack", ack, 1);
    check("R2 no delivery", rxCnt - r0, 0);
    check("R2 no match", matchCnt - m0, 0);
    busStop();
  endtask

  task automatic t_stretch();
    logic ack;
    int r0 = rxCnt;
    busStart();
    writeByte(OWN_W, ack);
    check("R1 address ack (stretch)", ack, 0);
    setRxReady(1'b0);
    stretchCyc = 0;
    fork
      writeByte(8'h81, ack);
      begin
        while (rxValid !== 1'b1) @(negedge clk);
        waitClk(40);
        check("R4 SCL held low", sclLine, 0);
        check("R4 sclOe", sclOe, 1);
        check("R3 rxData held", rxData, 8'h81);
        setRxReady(1'b1);
      end
    join
    check("R4 stretch observed", stretchCyc > 30, 1);
    check("R3 ack after take", ack, 0);
    check("R3 stretched byte", rxCap[r0[3:0]], 8'h81);
    busStop();
  endtask

  task automatic t_read();
    logic ack;
    logic [7:0] d;
    txMem[0] = 8'hC3; txMem[1] = 8'h5A;
    txIdx = 0; txLimit = 2;
    busStart();
    writeByte(OWN_R, ack);
    check("R1 read address ack", ack, 0);
    check("R10 matchRead read", lastRead, 1);
    fork
      readByte(d, 1'b0);
      begin
        waitClk(40);
        check("R5 SCL held for tx", sclLine, 0);
        check("R5 txReady", txReady, 1);
        setTxEnable(1'b1);
      end
    join
    check("R5 first byte", d, 8'hC3);
    readByte(d, 1'b1);
    check("R7 second byte", d, 8'h5A);
    waitClk(30);
    check("R6 no request after nack", txReady, 0);
    check("R6 SDA released", sdaOe, 0);
    check("R6 handshakes", txIdx, 2);
    busStop();
    setTxEnable(1'b0);
  endtask

  task automatic t_generalCall();
    logic ack;
    int r0 = rxCnt, m0;
    gcEnable = 1'b1;
    busStart();
    writeByte(8'h00, ack);
    check("R8 gc ack", ack, 0);
    check("R8 matchGc", lastGc, 1);
    writeByte(8'h77, ack);
    check("R8 gc data ack", ack, 0);
    check("R8 gc data", rxCap[r0[3:0]], 8'h77);
    busStop();
    gcEnable = 1'b0;
    m0 = matchCnt;
    busStart();
    writeByte(8'h00, ack);
    check("R8 gc ignored", ack, 1);
    check("R8 gc no match", matchCnt - m0, 0);
    busStop();
  endtask

  task automatic t_startByte();
    logic ack;
    gcEnable = 1'b1;
    busStart();
    writeByte(8'h01, ack);
    check("R9 start byte not acked", ack, 1);
    busStop();
    gcEnable = 1'b0;
    busStart();
    writeByte(8'h01, ack);
    check("R9 start byte not acked gc off", ack, 1);
    busStop();
  endtask

  task automatic t_restart();
    logic ack;
    logic [7:0] d;
    txMem[2] = 8'h9E;
    txIdx = 2; txLimit = 3;
    setTxEnable(1'b1);
    busStart();
    writeByte(OWN_W, ack);
    check("R11 write address", ack, 0);
    writeByte(8'h10, ack);
    check("R11 register byte", ack, 0);
    busStart();
    writeByte(OWN_R, ack);
    check("R11 read address after restart", ack, 0);
    check("R11 direction read", lastRead, 1);
    readByte(d, 1'b1);
    check("R11 read data", d, 8'h9E);
    busStart();
    writeByte(8'h90, ack);
    check("R11 wrong address after restart", ack, 1);
    busStart();
    writeByte(OWN_W, ack);
    check("R11 match after second restart", ack, 0);
    busStop();
    setTxEnable(1'b0);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
      $finish;
    end
  endtask

  initial begin
    waitClk(5);
    t_reset();
    rstN = 1'b1;
    waitClk(10);
    t_write();
    t_wrongAddr();
    t_stretch();
    t_read();
    t_generalCall();
    t_startByte();
    t_restart();
    waitClk(10);
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    nCompared++;
    nMismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule